// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Sensing

This block gives software control over a set of general-purpose pins organised in banks of 32. Each bank owns a window of registers, repeated every 0x200 bytes of the address space, through which software reads the synchronized pin levels. It also sets the driven value and the drive enable of each pin, chooses how each pin raises an interrupt, and services the latched interrupt status. The number of pins is a parameter. The last bank may be partly filled, and its unused bits behave as if they do not exist.

Incoming pin levels pass through a two-stage synchronizer before anything inside the block uses them. Each pin has three sense bits. One chooses between level and edge sensing. One lets both edges count. One chooses between rising/high and falling/low. A sensed event sets a sticky raw status bit, and software removes it by writing a one to the clear register. An enable register gates the raw status into a masked view. The single interrupt line is the registered OR of every masked bit in every bank.

The register bus is a plain 32-bit word interface with separate read and write strobes. Read data appears one cycle after the read strobe.

Top module: `gpio_banked`

## Requirements
- R1: Bank b's registers sit at byte address b*0x200 plus an offset. The offsets are 0x00 pin input (read-only), 0x04 output value, 0x08 drive enable, 0x0C sense kind, 0x10 both-edge select, 0x14 polarity, 0x18 interrupt enable, 0x1C raw status (read-only), 0x20 masked status (read-only) and 0x24 clear (write-one, reads zero). Any other offset, any bank at or beyond the bank count, and any bit for a pin at or beyond the pin count all read as zero.
- R2: `pin_out` carries each pin's output value bit and `pin_oe` carries its drive enable bit. Both change only when the register bus writes them.
- R3: The pin input register shows `pin_in` after two synchronizer stages. A level driven between clock edges is first returned by a read strobe presented two cycles later.
- R4: In edge mode (sense kind 0, both-edge 0), polarity 1 latches a rising edge and polarity 0 latches a falling edge of the synchronized input.
- R5: With both-edge set to 1 in edge mode, both rising and falling edges latch status, and the polarity bit has no effect.
- R6: In level mode (sense kind 1), polarity 1 latches while the input is high and polarity 0 latches while it is low. A clear takes effect for one cycle, and the bit sets again on the next cycle if the level persists.
- R7: Masked status equals raw status AND interrupt enable. `irq` is high exactly one cycle after any masked status bit in any bank is high.
- R8: Writing 1 to a clear bit removes that raw status bit and writing 0 leaves it unchanged. In edge mode, an edge detected in the same cycle as the clear keeps the bit set.
- R9: After reset, all registers, `pin_out`, `pin_oe`, `irq` and `bus_rdata` are zero.
- R10: `bus_rdata` holds the addressed register one cycle after a cycle with `bus_rd` high, and is zero after a cycle with `bus_rd` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| pin_in | input | NUM_PINS | Pad input levels, asynchronous |
| pin_out | output | NUM_PINS | Output value toward the pads |
| pin_oe | output | NUM_PINS | Drive enable toward the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that read and write strobes are never issued in the same cycle. They also assume that every status bit which falls was removed by a bus write, so the design must not lose status when the bus is idle. The bench drives the bus from sequential tasks that issue one access at a time. It changes `pin_in` only between clock edges and allows several settling cycles between pin patterns, except in the deliberately timed case where a clear collides with an edge. Sweeps cover every sense mode across all forty pins, including a partly filled second bank.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

  localparam int BANK_W      = 32;
  localparam int STRIDE_LOG2 = 9;

  localparam logic [STRIDE_LOG2-1:0] OFF_DIN  = 9'h000;
  localparam logic [STRIDE_LOG2-1:0] OFF_DOUT = 9'h004;
  localparam logic [STRIDE_LOG2-1:0] OFF_OE   = 9'h008;
  localparam logic [STRIDE_LOG2-1:0] OFF_KIND = 9'h00C;
  localparam logic [STRIDE_LOG2-1:0] OFF_BOTH = 9'h010;
  localparam logic [STRIDE_LOG2-1:0] OFF_POL  = 9'h014;
  localparam logic [STRIDE_LOG2-1:0] OFF_EN   = 9'h018;
  localparam logic [STRIDE_LOG2-1:0] OFF_RAW  = 9'h01C;
  localparam logic [STRIDE_LOG2-1:0] OFF_MSK  = 9'h020;
  localparam logic [STRIDE_LOG2-1:0] OFF_CLR  = 9'h024;

  // One pin's sense decision from its configuration and two samples.
  function automatic logic sense_hit(input logic is_level, input logic both,
                                     input logic pol, input logic cur,
                                     input logic prev);
    logic rise;
    logic fall;
    logic edge_hit;
    logic lvl_hit;
    rise     = cur & ~prev;
    fall     = ~cur & prev;
    edge_hit = both ? (rise | fall) : (pol ? rise : fall);
    lvl_hit  = pol ? cur : ~cur;
    return is_level ? lvl_hit : edge_hit;
  endfunction

endpackage

// File: rtl/gpio_banked_sync.sv
module gpio_banked_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      rst_q  <= stage1;
    end
  end
endmodule

module gpio_banked_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta   <= '0;
      q_sync <= '0;
    end else begin
      meta   <= d_async;
      q_sync <= meta;
    end
  end
endmodule

// File: rtl/gpio_banked_bank.sv
module gpio_banked_bank
  import gpio_banked_pkg::*;
#(
  parameter int VALID = 32
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   wr_en,
  input  logic [STRIDE_LOG2-1:0] off,
  input  logic [BANK_W-1:0]      wdata,
  input  logic [BANK_W-1:0]      in_sync,
  output logic [BANK_W-1:0]      rd_data,
  output logic [BANK_W-1:0]      pad_out,
  output logic [BANK_W-1:0]      pad_oe,
  output logic [BANK_W-1:0]      status,
  output logic [BANK_W-1:0]      enable,
  output logic                   hit_any
);

  localparam logic [BANK_W-1:0] VMASK =
    (VALID >= BANK_W) ? {BANK_W{1'b1}} : ((32'd1 << VALID) - 32'd1);

  logic [BANK_W-1:0] r_out,  n_out;
  logic [BANK_W-1:0] r_oe,   n_oe;
  logic [BANK_W-1:0] r_kind, n_kind;
  logic [BANK_W-1:0] r_both, n_both;
  logic [BANK_W-1:0] r_pol,  n_pol;
  logic [BANK_W-1:0] r_en,   n_en;
  logic [BANK_W-1:0] r_stat, n_stat;
  logic [BANK_W-1:0] r_prev;
  logic [BANK_W-1:0] hit;
  logic [BANK_W-1:0] clr;
  logic [BANK_W-1:0] din;

  assign din = in_sync & VMASK;

  // Per-pin sense decision
  for (genvar i = 0; i < BANK_W; i++) begin : g_sense
    assign hit[i] = sense_hit(r_kind[i], r_both[i], r_pol[i], din[i], r_prev[i]);
  end

  assign clr = (wr_en && off == OFF_CLR) ? (wdata & VMASK) : '0;

  // Configuration next state
  always_comb begin
    n_out  = r_out;
    n_oe   = r_oe;
    n_kind = r_kind;
    n_both = r_both;
    n_pol  = r_pol;
    n_en   = r_en;
    if (wr_en) begin
      case (off)
        OFF_DOUT: n_out  = wdata & VMASK;
        OFF_OE:   n_oe   = wdata & VMASK;
        OFF_KIND: n_kind = wdata & VMASK;
        OFF_BOTH: n_both = wdata & VMASK;
        OFF_POL:  n_pol  = wdata & VMASK;
        OFF_EN:   n_en   = wdata & VMASK;
        default:  ;
      endcase
    end
  end

  // Status next state: clear beats a level, an edge beats a clear
  always_comb begin
    for (int i = 0; i < BANK_W; i++) begin
      if (clr[i]) n_stat[i] = ~r_kind[i] & hit[i];
      else        n_stat[i] = r_stat[i] | hit[i];
    end
    n_stat = n_stat & VMASK;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      r_out  <= '0;
      r_oe   <= '0;
      r_kind <= '0;
      r_both <= '0;
      r_pol  <= '0;
      r_en   <= '0;
    end else if (wr_en) begin
      r_out  <= n_out;
      r_oe   <= n_oe;
      r_kind <= n_kind;
      r_both <= n_both;
      r_pol  <= n_pol;
      r_en   <= n_en;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      r_stat <= '0;
      r_prev <= '0;
    end else begin
      r_stat <= n_stat;
      r_prev <= din;
    end
  end

  // Register read view
  always_comb begin
    case (off)
      OFF_DIN:  rd_data = din;
      OFF_DOUT: rd_data = r_out;
      OFF_OE:   rd_data = r_oe;
      OFF_KIND: rd_data = r_kind;
      OFF_BOTH: rd_data = r_both;
      OFF_POL:  rd_data = r_pol;
      OFF_EN:   rd_data = r_en;
      OFF_RAW:  rd_data = r_stat;
      OFF_MSK:  rd_data = r_stat & r_en;
      default:  rd_data = '0;
    endcase
  end

  assign pad_out = r_out;
  assign pad_oe  = r_oe;
  assign status  = r_stat;
  assign enable  = r_en;
  assign hit_any = |(r_stat & r_en);

endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
  import gpio_banked_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);

  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int PAD       = NUM_BANKS * BANK_W;
  localparam int BIDX_W    = ADDR_W - STRIDE_LOG2;

  logic                   rst_q;
  logic [PAD-1:0]         in_pad;
  logic [PAD-1:0]         in_sync;
  logic [PAD-1:0]         out_pad;
  logic [PAD-1:0]         oe_pad;
  logic [PAD-1:0]         stat_flat;
  logic [PAD-1:0]         en_flat;
  logic [BANK_W-1:0]      bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0]   bank_hit;
  logic [BIDX_W-1:0]      bank_sel;
  logic [STRIDE_LOG2-1:0] off;
  logic [31:0]            rd_mux;
  logic [31:0]            rdata_n;
  logic                   irq_n;

  gpio_banked_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  assign in_pad = PAD'(pin_in);

  gpio_banked_sync #(.WIDTH(PAD)) u_sync (
    .clk     (clk),
    .rst_ni  (rst_q),
    .d_async (in_pad),
    .q_sync  (in_sync)
  );

  assign bank_sel = bus_addr[ADDR_W-1:STRIDE_LOG2];
  assign off      = bus_addr[STRIDE_LOG2-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int REM = NUM_PINS - b * BANK_W;
    localparam int VB  = (REM >= BANK_W) ? BANK_W : REM;

    gpio_banked_bank #(.VALID(VB)) u_bank (
      .clk     (clk),
      .rst_ni  (rst_q),
      .wr_en   (bus_wr && (bank_sel == BIDX_W'(b))),
      .off     (off),
      .wdata   (bus_wdata),
      .in_sync (in_sync[b*BANK_W +: BANK_W]),
      .rd_data (bank_rd[b]),
      .pad_out (out_pad[b*BANK_W +: BANK_W]),
      .pad_oe  (oe_pad[b*BANK_W +: BANK_W]),
      .status  (stat_flat[b*BANK_W +: BANK_W]),
      .enable  (en_flat[b*BANK_W +: BANK_W]),
      .hit_any (bank_hit[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BIDX_W'(b)) rd_mux = bank_rd[b];
    end
  end

  assign rdata_n = bus_rd ? rd_mux : '0;
  assign irq_n   = |bank_hit;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rdata_n;
      irq       <= irq_n;
    end
  end

  assign pin_out = out_pad[NUM_PINS-1:0];
  assign pin_oe  = oe_pad[NUM_PINS-1:0];

endmodule

// File: rtl/gpio_banked_checker.sv
module gpio_banked_checker #(
  parameter int NUM_PINS = 40,
  parameter int PAD      = 64
) (
  input logic                clk,
  input logic                rst_q,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq,
  input logic [PAD-1:0]      stat_flat,
  input logic [PAD-1:0]      en_flat
);

  // R10: no read strobe, no read data
  a_r10_rdata_idle: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_rd |=> bus_rdata == 32'd0);

  // R2: pad controls move only on a bus write
  a_r2_pads_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_wr |=> ($stable(pin_oe) && $stable(pin_out)));

  // R8: a status bit only drops after a bus write
  a_r8_drop_needs_write: assert property (@(posedge clk) disable iff (!rst_q)
    (|($past(stat_flat) & ~stat_flat)) |-> $past(bus_wr));

  // R7: any enabled pending status raises irq next cycle
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_q)
    (|(stat_flat & en_flat)) |=> irq);

  // R7: irq can only rise when some enable bit was set
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(irq) |-> $past(|en_flat));

endmodule

bind gpio_banked gpio_banked_checker #(.NUM_PINS(NUM_PINS), .PAD(PAD)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .stat_flat (stat_flat),
  .en_flat   (en_flat)
);

// File: tb/gpio_banked_test.sv
module gpio_banked_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 40;
  localparam int AW = 12;

  logic          clk;
  logic          rst_n;
  logic          bus_wr;
  logic          bus_rd;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  gpio_banked #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bus tasks: called right after a falling edge, return after the next one
  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [NP-1:0] pat(input int n);
    logic [63:0] t;
    t = {32'(n * 32'h9E3779B9) ^ 32'h5A5A1234, 32'(n * 32'h85EBCA6B + 32'h13)};
    return t[NP-1:0];
  endfunction

  // Expected raw status after A then B, following R4/R5/R6
  function automatic logic [NP-1:0] exp_raw(input int m, input logic [NP-1:0] a,
                                            input logic [NP-1:0] b);
    case (m)
      0: return ~a & b;
      1: return a & ~b;
      2, 3: return a ^ b;
      4: return a | b;
      default: return ~a | ~b;
    endcase
  endfunction

  task automatic set_mode(input int m);
    logic [31:0] kind, both, pol;
    kind = (m >= 4) ? 32'hFFFF_FFFF : 32'h0;
    both = (m == 2 || m == 3) ? 32'hFFFF_FFFF : 32'h0;
    pol  = (m == 0 || m == 3 || m == 4) ? 32'hFFFF_FFFF : 32'h0;
    for (int b = 0; b < 2; b++) begin
      wr(b*32'h200 + 32'h0C, kind);
      wr(b*32'h200 + 32'h10, both);
      wr(b*32'h200 + 32'h14, pol);
    end
  endtask

  task automatic clear_all();
    wr(32'h024, 32'hFFFF_FFFF);
    wr(32'h224, 32'hFFFF_FFFF);
  endtask

  // Watchdog
  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [NP-1:0] a, b, e, msk;
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R9: reset state
    chk("R9 pin_out", 64'(pin_out), 64'h0);
    chk("R9 pin_oe", 64'(pin_oe), 64'h0);
    chk("R9 irq", 64'(irq), 64'h0);
    chk("R9 rdata", 64'(bus_rdata), 64'h0);
    for (int bk = 0; bk < 2; bk++)
      for (int o = 0; o <= 32'h24; o += 4) begin
        rd(bk*32'h200 + o, v);
        chk("R9 register zero", 64'(v), 64'h0);
      end

    // R2 and R1: pad controls, partial bank, stride
    wr(32'h004, 32'hDEAD_BEEF);
    wr(32'h008, 32'h0F0F_00FF);
    wr(32'h204, 32'hFFFF_FFFF);
    wr(32'h208, 32'h0000_00A5);
    chk("R2 pin_out", 64'(pin_out), 64'h0000_00FF_DEAD_BEEF);
    chk("R2 pin_oe", 64'(pin_oe), 64'h0000_00A5_0F0F_00FF);
    rd(32'h204, v); chk("R1 bank1 dout partial", 64'(v), 64'hFF);
    rd(32'h004, v); chk("R1 bank0 dout", 64'(v), 64'hDEAD_BEEF);
    rd(32'h028, v); chk("R1 unused offset", 64'(v), 64'h0);
    rd(32'h006, v); chk("R1 unaligned offset", 64'(v), 64'h0);
    rd(32'h404, v); chk("R1 absent bank", 64'(v), 64'h0);
    wr(32'h404, 32'h1234_5678);
    chk("R2 absent bank write ignored", 64'(pin_out), 64'h0000_00FF_DEAD_BEEF);
    idle(1);
    chk("R10 rdata idle", 64'(bus_rdata), 64'h0);

    // R3: synchronizer latency on the pin input register
    pin_in = 40'hAB_1234_5678;
    rd(32'h000, v); chk("R3 first read old", 64'(v), 64'h0);
    rd(32'h000, v); chk("R3 second read old", 64'(v), 64'h0);
    rd(32'h000, v); chk("R3 third read new", 64'(v), 64'h1234_5678);
    rd(32'h200, v); chk("R3 bank1 input", 64'(v), 64'hAB);
    pin_in = '0;
    idle(5);

    // R4 R5 R6 R7: sweep sense modes over all pins
    for (int m = 0; m < 6; m++) begin
      for (int k = 0; k < 4; k++) begin
        a = pat(2*k + 7*m);
        b = pat(2*k + 7*m + 1);
        if (k == 0) begin a = '0; b = '1; end
        wr(32'h018, 32'h0); wr(32'h218, 32'h0);
        set_mode(m);
        pin_in = a;
        idle(5);
        clear_all();
        pin_in = b;
        idle(5);
        e = exp_raw(m, a, b);
        rd(32'h01C, v); chk($sformatf("R4 R5 R6 raw bank0 mode%0d", m), 64'(v), 64'(e[31:0]));
        rd(32'h21C, v); chk($sformatf("R4 R5 R6 raw bank1 mode%0d", m), 64'(v), 64'(e[39:32]));
        msk = pat(100 + k + m);
        wr(32'h018, msk[31:0]);
        wr(32'h218, {24'h0, msk[39:32]});
        rd(32'h020, v); chk("R7 masked bank0", 64'(v), 64'(e[31:0] & msk[31:0]));
        rd(32'h220, v); chk("R7 masked bank1", 64'(v), 64'(e[39:32] & msk[39:32]));
        idle(1);
        chk("R7 irq", 64'(irq), 64'(|(e & msk)));
      end
    end

    // R7: disable all, irq drops
    wr(32'h018, 32'h0); wr(32'h218, 32'h0);
    idle(2);
    chk("R7 irq off when disabled", 64'(irq), 64'h0);

    // R6: level re-sets one cycle after clear
    pin_in = '0;
    set_mode(4);
    pin_in[5] = 1'b1;
    idle(5);
    clear_all();
    idle(1);
    rd(32'h01C, v); chk("R6 level set", 64'(v[5]), 64'h1);
    wr(32'h024, 32'h20);
    rd(32'h01C, v); chk("R6 clear visible", 64'(v[5]), 64'h0);
    rd(32'h01C, v); chk("R6 level sets again", 64'(v[5]), 64'h1);

    // R8: write-one clear, zero ignored, edge wins over clear
    pin_in = '0;
    set_mode(2);
    idle(5);
    clear_all();
    pin_in[0] = 1'b1;
    idle(5);
    rd(32'h01C, v); chk("R8 edge latched", 64'(v), 64'h1);
    wr(32'h024, 32'h0);
    rd(32'h01C, v); chk("R8 zero write no effect", 64'(v), 64'h1);
    rd(32'h024, v); chk("R8 clear reads zero", 64'(v), 64'h0);
    pin_in[0] = 1'b0;
    idle(2);
    wr(32'h024, 32'h1);
    rd(32'h01C, v); chk("R8 edge beats clear", 64'(v), 64'h1);
    wr(32'h024, 32'h1);
    rd(32'h01C, v); chk("R8 clear removes bit", 64'(v), 64'h0);

    // R5: polarity ignored in dual mode, falling edge on bank1 pin
    set_mode(3);
    pin_in[37] = 1'b1;
    idle(5);
    clear_all();
    pin_in[37] = 1'b0;
    idle(5);
    rd(32'h21C, v); chk("R5 falling with polarity 1", 64'(v), 64'h20);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule